// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from peripherals and from external pins. Each source has a pending flag, an enable bit and a 3-bit priority. The flags are loaded only on an instruction-cycle strobe. The block keeps the CPU's current 4-bit priority level. When the best pending, enabled source has a priority strictly above that level, the block raises a vector request that carries the source index.

When the CPU takes the vector, the block presents two values for the stack: the return PC, and a status byte that holds the old level. In the same cycle it raises the current level to the priority of the accepted source. On return the CPU hands back the popped status byte, and the level is restored from it. The external pins pass through edge detectors, and a per-pin bit selects the rising or the falling edge. A nesting-disable input stops any preemption while a handler is active. Tied priorities go to the lowest source index. A wake output reports any pending enabled source, whatever its priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Events are collected between strobes. They appear in `flags` only after a clock edge at which `cycle_start` is 1, and not earlier.
- R2: A source can produce `irq_req` only when both its flag bit and its `enable` bit are 1.
- R3: `irq_req` is 1 only when the 3-bit priority of the winning source, zero-extended, is strictly greater than `cur_level`. A source with priority 0 is therefore never taken at level 0.
- R4: In a cycle with `take`=1 and `irq_req`=1, the entry values are presented. `push_en`=1, `push_pc`=`pc_in`, and `push_sr`={4'b0000, `cur_level`}. After that edge, `cur_level` equals the accepted priority.
- R5: In a cycle with `ret`=1, `cur_level` takes `pop_sr[3:0]` at the next edge. `ret` has precedence over `take`.
- R6: After the entry of an ordinary interrupt, bit 3 of `cur_level` is 0.
- R7: Source i, for i below NUM_EXT, is driven only by pin i and ignores `periph_req[i]`. `ext_fall[i]`=0 selects the rising edge and 1 selects the falling edge. The opposite edge sets no flag.
- R8: Entry does not clear a flag. Only `flag_clr` clears one.
- R9: After reset, `flags`, `cur_level`, `irq_req` and `wake` are all 0. A flag bit that is 0 in IMPL_MASK (default 8'hBF, so bit 6) always reads 0 and never requests.
- R10: When `nest_dis`=1 and a handler is active (more entries than returns), `irq_req` is 0.
- R11: Among winners of equal priority, the lowest source index is reported in `irq_id`.
- R12: `wake` is 1 exactly when some source has both its flag and its enable set, independent of its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | Instruction-cycle strobe; flags load at this edge |
| periph_req | input | NUM_SRC | Peripheral request pulses, one per source |
| ext_pin | input | NUM_EXT | External interrupt pins |
| ext_fall | input | NUM_EXT | Edge select per pin: 0 rising, 1 falling |
| flag_clr | input | NUM_SRC | Software clear, one bit per flag |
| enable | input | NUM_SRC | Per-source enable |
| prio_cfg | input | 3*NUM_SRC | Per-source priority; source i uses bits [3i+2:3i] |
| nest_dis | input | 1 | Forbid preemption of an active handler |
| take | input | 1 | CPU accepts the vector this cycle |
| pc_in | input | PC_W | PC to be saved on entry |
| ret | input | 1 | Return from handler this cycle |
| pop_sr | input | 8 | Status byte popped on return |
| irq_req | output | 1 | Vector request |
| irq_id | output | ID_W | Index of the winning source |
| irq_prio | output | 3 | Priority of the winning source |
| push_en | output | 1 | Entry values are valid |
| push_pc | output | PC_W | PC to push |
| push_sr | output | 8 | Status byte to push, old level in bits [3:0] |
| cur_level | output | 4 | Current priority level |
| wake | output | 1 | Pending enabled source exists |
| flags | output | NUM_SRC | Pending flag bits |

## Verification
The bench targets five corner cases.

- **Priority equal to the level.** A level compare that used greater-or-equal instead of strictly greater would re-enter its own handler forever.
- **Tied priorities.** A wrong scan order would report the higher index.
- **Unimplemented flag bit.** If the mask were missing, that bit would raise a request for a source that does not exist.
- **Opposite pin edge.** If edge polarity were mishandled, the wrong transition would set a flag.
- **Flag between strobes.** Early loading would show the flag before the strobe.

Nested entry and return are also exercised. The bench checks the stacked status byte and the restored level, which catches a design that pushes the new level or restores a stale one. With nesting disabled, the bench checks that a higher-priority source is held off while a handler is active.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef logic [3:0] level_t;
  typedef logic [2:0] prio_t;

  // Candidate replaces the current best when priority is at least as high;
  // scanning from the top index down makes the lowest index win ties.
  function automatic logic prio_beats(input prio_t cand, input prio_t best, input logic have);
    return !have || (cand >= best);
  endfunction

  function automatic logic [7:0] pack_sr(input level_t lvl);
    return {4'b0000, lvl};
  endfunction

  function automatic logic above_level(input prio_t p, input level_t lvl);
    return {1'b0, p} > lvl;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] pin,
  input  logic [NUM_EXT-1:0] fall_sel,
  output logic [NUM_EXT-1:0] edge_evt
);
  logic [NUM_EXT-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin;
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
    logic rise_w, fall_w;
    assign rise_w = pin[i] & ~pin_q[i];
    assign fall_w = ~pin[i] & pin_q[i];
    assign edge_evt[i] = fall_sel[i] ? fall_w : rise_w;
  end

  assert_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt[0] && !fall_sel[0]) |-> (pin[0] && !pin_q[0]));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int              NUM_SRC   = 8,
  parameter logic [NUM_SRC-1:0] IMPL_MASK = 8'hBF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_start,
  input  logic [NUM_SRC-1:0] events,
  input  logic [NUM_SRC-1:0] flag_clr,
  output logic [NUM_SRC-1:0] flags
);
  logic [NUM_SRC-1:0] ev_hold;
  logic [NUM_SRC-1:0] ev_all;

  assign ev_all = (ev_hold | events) & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_hold <= '0;
      flags   <= '0;
    end else begin
      if (cycle_start) begin
        ev_hold <= '0;
        flags   <= (flags & ~flag_clr) | ev_all;
      end else begin
        ev_hold <= ev_all;
        flags   <= flags & ~flag_clr;
      end
    end
  end

  assert_no_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr == '0) |=> ((flags & $past(flags)) == $past(flags)));
  assert_strobe_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> ((flags & ~$past(flags)) == '0));
  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~IMPL_MASK) == '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   flags,
  input  logic [NUM_SRC-1:0]   enable,
  input  logic [3*NUM_SRC-1:0] prio_cfg,
  output logic                 best_valid,
  output logic [ID_W-1:0]      best_id,
  output prio_t                best_prio
);
  logic [NUM_SRC-1:0] live;
  assign live = flags & enable;

  always_comb begin
    best_valid = 1'b0;
    best_id    = '0;
    best_prio  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i] && prio_beats(prio_t'(prio_cfg[3*i +: 3]), best_prio, best_valid)) begin
        best_valid = 1'b1;
        best_id    = ID_W'(i);
        best_prio  = prio_t'(prio_cfg[3*i +: 3]);
      end
    end
  end

  assert_winner_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (flags[best_id] && enable[best_id]));
  assert_tie_low_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && best_id != '0 && live[0]) |-> (prio_t'(prio_cfg[2:0]) < best_prio));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 NUM_EXT   = 2,
  parameter int                 PC_W      = 16,
  parameter int                 DEPTH_W   = 4,
  parameter logic [NUM_SRC-1:0] IMPL_MASK = 8'hBF,
  localparam int                ID_W      = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cycle_start,
  input  logic [NUM_SRC-1:0]   periph_req,
  input  logic [NUM_EXT-1:0]   ext_pin,
  input  logic [NUM_EXT-1:0]   ext_fall,
  input  logic [NUM_SRC-1:0]   flag_clr,
  input  logic [NUM_SRC-1:0]   enable,
  input  logic [3*NUM_SRC-1:0] prio_cfg,
  input  logic                 nest_dis,
  input  logic                 take,
  input  logic [PC_W-1:0]      pc_in,
  input  logic                 ret,
  input  logic [7:0]           pop_sr,
  output logic                 irq_req,
  output logic [ID_W-1:0]      irq_id,
  output logic [2:0]           irq_prio,
  output logic                 push_en,
  output logic [PC_W-1:0]      push_pc,
  output logic [7:0]           push_sr,
  output logic [3:0]           cur_level,
  output logic                 wake,
  output logic [NUM_SRC-1:0]   flags
);
  logic [NUM_EXT-1:0] ext_evt;
  logic [NUM_SRC-1:0] src_evt;
  logic               best_valid;
  prio_t              best_prio;
  logic [DEPTH_W-1:0] depth;
  logic               handler_active;
  logic               entry_fire;
  logic               nest_block;

  irq_edge_det #(.NUM_EXT(NUM_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall_sel(ext_fall), .edge_evt(ext_evt)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_EXT) begin : g_ext
      assign src_evt[i] = ext_evt[i];
    end else begin : g_per
      assign src_evt[i] = periph_req[i];
    end
  end

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .IMPL_MASK(IMPL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .events(src_evt), .flag_clr(flag_clr), .flags(flags)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .flags(flags), .enable(enable), .prio_cfg(prio_cfg),
    .best_valid(best_valid), .best_id(irq_id), .best_prio(best_prio)
  );

  assign handler_active = (depth != '0);
  assign nest_block     = nest_dis && handler_active;
  assign irq_prio       = best_prio;
  assign irq_req        = best_valid && above_level(best_prio, cur_level) && !nest_block;
  assign wake           = |(flags & enable);
  assign entry_fire     = take && irq_req && !ret;
  assign push_en        = entry_fire;
  assign push_pc        = pc_in;
  assign push_sr        = pack_sr(cur_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_level <= '0;
      depth     <= '0;
    end else if (ret) begin
      cur_level <= pop_sr[3:0];
      if (handler_active) depth <= depth - 1'b1;
    end else if (entry_fire) begin
      cur_level <= {1'b0, best_prio};
      if (depth != '1) depth <= depth + 1'b1;
    end
  end

  assert_above_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, irq_prio} > cur_level));
  assert_entry_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (cur_level == {1'b0, $past(irq_prio)}));
  assert_return_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret |=> (cur_level == $past(pop_sr[3:0])));
  assert_bit3_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> !cur_level[3]);
  assert_no_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_dis && depth != '0) |-> !irq_req);
  assert_wake_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, cycle_start = 0, nest_dis = 0, take = 0, ret = 0;
  logic [N-1:0] periph_req = '0, flag_clr = '0, enable = '0;
  logic [1:0] ext_pin = '0, ext_fall = '0;
  logic [3*N-1:0] prio_cfg = '0;
  logic [15:0] pc_in = '0;
  logic [7:0] pop_sr = '0;
  logic irq_req, push_en, wake;
  logic [2:0] irq_id, irq_prio;
  logic [15:0] push_pc;
  logic [7:0] push_sr;
  logic [3:0] cur_level;
  logic [N-1:0] flags;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .periph_req(periph_req),
    .ext_pin(ext_pin), .ext_fall(ext_fall), .flag_clr(flag_clr), .enable(enable),
    .prio_cfg(prio_cfg), .nest_dis(nest_dis), .take(take), .pc_in(pc_in), .ret(ret),
    .pop_sr(pop_sr), .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
    .push_en(push_en), .push_pc(push_pc), .push_sr(push_sr), .cur_level(cur_level),
    .wake(wake), .flags(flags)
  );

  // {req[8], en[8], prio nibbles[32], exp_req, exp_id[3]}
  localparam logic [51:0] TBL [8] = '{
    {8'h04, 8'h04, 32'h0000_0300, 1'b1, 3'd2},
    {8'h04, 8'h00, 32'h0000_0300, 1'b0, 3'd0},
    {8'h0C, 8'h0C, 32'h0000_5200, 1'b1, 3'd3},
    {8'h0C, 8'h0C, 32'h0000_4400, 1'b1, 3'd2},
    {8'h24, 8'h24, 32'h0000_0000, 1'b0, 3'd0},
    {8'h80, 8'h80, 32'h1000_0000, 1'b1, 3'd7},
    {8'h40, 8'h40, 32'h0700_0000, 1'b0, 3'd0},
    {8'hA4, 8'hA0, 32'h3030_0700, 1'b1, 3'd5}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [3*N-1:0] nib_to_prio(input logic [31:0] nib);
    logic [3*N-1:0] r;
    for (int i = 0; i < N; i++) r[3*i +: 3] = nib[4*i +: 3];
    return r;
  endfunction

  task automatic clear_all();
    flag_clr = '1; step(); flag_clr = '0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    #1;
    // R9 reset state
    chk(flags == 0, "R9 flags after reset", flags, 0);
    chk(cur_level == 0, "R9 level after reset", cur_level, 0);
    chk(!irq_req && !wake, "R9 req/wake after reset", {irq_req, wake}, 0);
    step();

    // vector table: R2 R3 R9 R11 R12
    for (int k = 0; k < 8; k++) begin
      logic [7:0] rq, en;
      logic [31:0] pn;
      logic er;
      logic [2:0] eid;
      {rq, en, pn, er, eid} = TBL[k];
      clear_all();
      periph_req = rq; cycle_start = 1; step();
      periph_req = '0; cycle_start = 0;
      enable = en; prio_cfg = nib_to_prio(pn);
      #1;
      chk(irq_req == er, $sformatf("R2/R3/R9 table %0d irq_req", k), irq_req, er);
      if (er) chk(irq_id == eid, $sformatf("R11 table %0d irq_id", k), irq_id, eid);
      chk(wake == |(rq & en & 8'hBF), $sformatf("R12 table %0d wake", k), wake, |(rq & en & 8'hBF));
      step();
    end
    enable = '0; prio_cfg = '0;

    // R1 event held until strobe
    clear_all();
    periph_req = 8'h04; step(); periph_req = '0; step();
    chk(flags == 0, "R1 no load without strobe", flags, 0);
    cycle_start = 1; step(); cycle_start = 0;
    chk(flags == 8'h04, "R1 load at strobe", flags, 8'h04);

    // R12 flag pending but disabled: no wake
    #1; chk(!wake, "R12 disabled source no wake", wake, 0);

    // R4 entry, R6, R8, R3 equal level
    enable = 8'h0C; prio_cfg = nib_to_prio(32'h0000_6500);
    pc_in = 16'h1234; take = 1; #1;
    chk(push_en && push_pc == 16'h1234, "R4 push pc", push_pc, 16'h1234);
    chk(push_sr == 8'h00, "R4 push status", push_sr, 0);
    step(); take = 0; #1;
    chk(cur_level == 4'd5, "R4 level raised", cur_level, 5);
    chk(!cur_level[3], "R6 bit3 clear", cur_level, 5);
    chk(flags[2], "R8 flag survives entry", flags, 8'h04);
    chk(!irq_req, "R3 equal priority not taken", irq_req, 0);

    // preemption / nesting disable R10
    periph_req = 8'h08; cycle_start = 1; step(); periph_req = '0; cycle_start = 0; #1;
    chk(irq_req && irq_id == 3, "R10 preempt allowed when nesting on", irq_id, 3);
    nest_dis = 1; #1;
    chk(!irq_req, "R10 preempt blocked", irq_req, 0);
    nest_dis = 0; #1;
    take = 1; #1;
    chk(push_sr == 8'h05, "R4 nested push status", push_sr, 5);
    step(); take = 0;
    chk(cur_level == 4'd6, "R4 nested level", cur_level, 6);

    // R5 returns
    ret = 1; pop_sr = 8'h05; step(); ret = 0;
    chk(cur_level == 4'd5, "R5 restore first", cur_level, 5);
    ret = 1; pop_sr = 8'h00; step(); ret = 0;
    chk(cur_level == 4'd0, "R5 restore second", cur_level, 0);

    // R7 edge polarity
    enable = '0; clear_all();
    ext_fall = 2'b10; ext_pin = 2'b10; periph_req = 8'h03; cycle_start = 1; step();
    periph_req = '0;
    chk(flags == 0, "R7 rising ignored on falling pin / periph ignored", flags, 0);
    ext_pin = 2'b00; step();
    chk(flags == 8'h02, "R7 falling edge sets flag", flags, 2);
    ext_pin = 2'b01; step();
    chk(flags == 8'h03, "R7 rising edge sets flag", flags, 3);
    cycle_start = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule